// File: doc/BRIEF.md
# Cycle Timer Glitch-Rejecting Sampler

This block fetches a 32-bit cycle timer word from a timer that can misbehave and hands back a value it trusts. Each word splits into a seconds field, a cycle-count field and a sub-cycle offset field. The block turns each word into a linear tick count so that two readings can be compared by subtraction. It keeps the three most recent readings. It accepts the newest one when both forward steps between them are positive and neither step is at least twice the other. This catches the faults a real timer can show: corrupted low bits near an offset roll-over, a count field that lags just after the offset wraps, and a word that reads as all zeros.

A client pulses `start`. The block then fetches readings through a request/valid handshake, waiting a set number of clocks between fetches so that each step spans a measurable number of ticks. It pulses `done` with the result. In bypass mode (check enable low) one reading is returned with no checks. In checked mode the retry budget is bounded. If the budget runs out, the newest reading is still returned and an error flag is raised.

Top module: `ctmr_sampler`

## Requirements
- R1: While reset is held and right after it, `smp_req`, `done` and `err` are low and `result` is zero.
- R2: A word converts to ticks as offset + 3072*count + 24576000*seconds, with offset in bits 11:0, count in bits 24:12 and seconds in bits 31:25. Readings that straddle an offset or seconds roll-over are compared in ticks, not as raw words.
- R3: With `checked_mode` low at `start`, exactly one reading is fetched and returned unchanged with `err` low, even if it is zero.
- R4: With `checked_mode` high at `start`, two readings prime the window. Every later reading shifts the window so that it holds the three newest readings, and the window is judged after each such reading.
- R5: A window is rejected when either tick step (middle minus oldest, newest minus middle, as signed 32-bit values) is zero or negative.
- R6: A window is rejected when either step is greater than or equal to twice the other. A ratio of exactly 2 is rejected, and any ratio below 2 is accepted.
- R7: On an accepted window, `done` pulses with `result` equal to the newest reading and `err` low.
- R8: At most 21 windows are judged (one first try plus 20 retries), so at most 23 readings are fetched. If the 21st window is rejected, `done` pulses with the newest reading and `err` high. If it is accepted, `err` stays low.
- R9: `smp_req` stays high until a cycle with `smp_vld` high and is low in the next cycle. Within one run, a new request rises only after more than `GAP_CYCLES` clocks have passed since the previous valid cycle.
- R10: `done` is a single-cycle pulse. `result` and `err` change only in a cycle with `done` high and hold their values until the next run finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a fetch run when the block is idle |
| checked_mode | input | 1 | Sampled at start: high enables window checking, low selects bypass |
| smp_req | output | 1 | Request for one timer reading |
| smp_vld | input | 1 | Timer reading is present on `smp_data` |
| smp_data | input | 32 | Timer reading (seconds, count, offset) |
| result | output | 32 | Returned timer reading |
| done | output | 1 | One-cycle pulse marking the end of a run |
| err | output | 1 | Retry budget used up without an accepted window |

## Verification
The bench targets the exact-2 ratio boundary, with a lag that makes one step exactly double the other and a lag one tick smaller. A design using strict greater-than, or one that swaps the operands, would return a reading one fetch early or one fetch late. Offset and seconds roll-overs are included so that a design comparing raw words instead of ticks would reject clean readings and fetch too many. The retry limit is probed from both sides: all-zero readings must stop after exactly 23 fetches with the error flag set, and a window first accepted on the final try must clear the flag. An off-by-one in the retry counter shows up as a wrong fetch count or a wrong flag. Zero reads placed first, in the middle and in bypass mode check that negative steps, huge steps and unchecked returns are each handled as specified.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int unsigned OFFS_PER_CYCLE = 3072;
    localparam int unsigned CYCLES_PER_SEC = 8000;
    localparam int unsigned TICKS_PER_SEC  = OFFS_PER_CYCLE * CYCLES_PER_SEC;

    typedef struct packed {
        logic [6:0]  sec;
        logic [12:0] cyc;
        logic [11:0] offs;
    } ct_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_GAP,
        ST_JUDGE
    } smp_state_e;

endpackage

// File: rtl/ctmr_tick_conv.sv
module ctmr_tick_conv
    import ctmr_pkg::*;
(
    input  logic [31:0] raw,
    output logic [31:0] ticks
);
    ct_word_t w;

    always_comb begin
        w     = ct_word_t'(raw);
        // R2: linear tick count from the three fields
        ticks = 32'(w.offs)
              + 32'(w.cyc) * 32'(OFFS_PER_CYCLE)
              + 32'(w.sec) * 32'(TICKS_PER_SEC);
    end
endmodule

// File: rtl/ctmr_window_judge.sv
module ctmr_window_judge
    import ctmr_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic [DEPTH-1:0][31:0] win,
    output logic                   ok
);
    logic [DEPTH-1:0][31:0] t;
    logic [31:0] d_old, d_new;
    logic        pos_old, pos_new, skew_a, skew_b;

    for (genvar g = 0; g < DEPTH; g++) begin : g_conv
        ctmr_tick_conv u_conv (
            .raw   (win[g]),
            .ticks (t[g])
        );
    end

    always_comb begin
        d_old   = t[1] - t[0];
        d_new   = t[2] - t[1];
        // R5: signed steps must be strictly positive
        pos_old = !d_old[31] && (d_old != 32'd0);
        pos_new = !d_new[31] && (d_new != 32'd0);
        // R6: ratio test without a divider, 33-bit to avoid overflow
        skew_a  = {1'b0, d_old} >= {d_new, 1'b0};
        skew_b  = {1'b0, d_new} >= {d_old, 1'b0};
        ok      = pos_old && pos_new && !skew_a && !skew_b;
    end
endmodule

// File: rtl/ctmr_sampler.sv
module ctmr_sampler
    import ctmr_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 4,
    parameter int unsigned RETRY_MAX  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        checked_mode,
    output logic        smp_req,
    input  logic        smp_vld,
    input  logic [31:0] smp_data,
    output logic [31:0] result,
    output logic        done,
    output logic        err
);
    localparam int unsigned DEPTH = 3;
    localparam int unsigned TRY_W = $clog2(RETRY_MAX + 1);
    localparam int unsigned GAP_W = $clog2(GAP_CYCLES + 1) + 1;
    localparam int unsigned SNC_W = GAP_W + 1;

    typedef struct packed {
        smp_state_e             state;
        logic [DEPTH-1:0][31:0] win;
        logic [1:0]             nsmp;
        logic [TRY_W-1:0]       tries;
        logic [GAP_W-1:0]       gap;
        logic                   mode;
        logic                   req;
        logic                   done;
        logic                   err;
        logic [31:0]            result;
    } regs_t;

    regs_t r_d, r_q;
    logic  win_ok;

    ctmr_window_judge #(.DEPTH(DEPTH)) u_judge (
        .win (r_q.win),
        .ok  (win_ok)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_REQ;
                    r_d.req   = 1'b1;
                    r_d.nsmp  = '0;
                    r_d.tries = '0;
                    r_d.mode  = checked_mode;
                end
            end
            ST_REQ: begin
                if (smp_vld) begin
                    r_d.req = 1'b0;
                    r_d.win = {smp_data, r_q.win[DEPTH-1:1]};
                    if (!r_q.mode) begin
                        r_d.result = smp_data;
                        r_d.err    = 1'b0;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end else if (r_q.nsmp != 2'd2) begin
                        r_d.nsmp  = r_q.nsmp + 2'd1;
                        r_d.gap   = GAP_W'(GAP_CYCLES);
                        r_d.state = ST_GAP;
                    end else begin
                        r_d.state = ST_JUDGE;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap == '0) begin
                    r_d.state = ST_REQ;
                    r_d.req   = 1'b1;
                end else begin
                    r_d.gap = r_q.gap - GAP_W'(1);
                end
            end
            ST_JUDGE: begin
                if (win_ok || r_q.tries == TRY_W'(RETRY_MAX)) begin
                    r_d.result = r_q.win[DEPTH-1];
                    r_d.err    = !win_ok;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end else begin
                    r_d.tries = r_q.tries + TRY_W'(1);
                    r_d.gap   = GAP_W'(GAP_CYCLES);
                    r_d.state = ST_GAP;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign smp_req = r_q.req;
    assign result  = r_q.result;
    assign done    = r_q.done;
    assign err     = r_q.err;

    // Checker state: clocks since the last accepted reading
    logic [SNC_W-1:0] since_vld_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                                 since_vld_q <= '0;
        else if (smp_req && smp_vld)                since_vld_q <= '0;
        else if (since_vld_q != SNC_W'(GAP_CYCLES + 1)) since_vld_q <= since_vld_q + SNC_W'(1);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req && !smp_vld |=> smp_req);                          // R9
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req && smp_vld |=> !smp_req);                          // R9
    AST_GAP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_req) && !$past(start) |-> since_vld_q > SNC_W'(GAP_CYCLES)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result) && $stable(err));                // R10
    AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tries <= TRY_W'(RETRY_MAX));                           // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);                                      // R8
endmodule

// File: tb/sim_ctmr_sampler.sv
`timescale 1ns/1ps
module sim_ctmr_sampler;
    localparam int GAP = 4;
    localparam longint TPS = 64'd24576000;

    typedef struct packed {
        logic        mode;
        logic [3:0]  rq;
        logic [31:0] base;
        logic [31:0] step;
        logic [31:0] lag;
        logic [31:0] zmask;
        logic [31:0] lmask;
        logic [7:0]  n;
        logic        err;
    } vec_t;

    // mode, req, base, step, lag, zero-mask, lag-mask, fetches, err
    localparam vec_t VECS [12] = '{
        '{1'b0, 4'd3, 32'd5000,     32'd90,  32'd0,  32'h0,        32'h0, 8'd1,  1'b0}, // R3 clean bypass
        '{1'b0, 4'd3, 32'd5000,     32'd90,  32'd0,  32'h1,        32'h0, 8'd1,  1'b0}, // R3 zero returned unchecked
        '{1'b1, 4'd7, 32'd5000,     32'd90,  32'd0,  32'h0,        32'h0, 8'd3,  1'b0}, // R7 R4 first window
        '{1'b1, 4'd5, 32'd5000,     32'd90,  32'd0,  32'h4,        32'h0, 8'd6,  1'b0}, // R5 zero mid-stream
        '{1'b1, 4'd6, 32'd5000,     32'd90,  32'd0,  32'h1,        32'h0, 8'd4,  1'b0}, // R6 zero first
        '{1'b1, 4'd6, 32'd5000,     32'd90,  32'd30, 32'h0,        32'h2, 8'd4,  1'b0}, // R6 ratio exactly 2
        '{1'b1, 4'd6, 32'd5000,     32'd90,  32'd29, 32'h0,        32'h2, 8'd3,  1'b0}, // R6 ratio below 2
        '{1'b1, 4'd6, 32'd5000,     32'd100, 32'd60, 32'h0,        32'h4, 8'd5,  1'b0}, // R6 lagging count
        '{1'b1, 4'd2, 32'd18360,    32'd100, 32'd0,  32'h0,        32'h0, 8'd3,  1'b0}, // R2 offset wrap
        '{1'b1, 4'd2, 32'd73727850, 32'd100, 32'd0,  32'h0,        32'h0, 8'd3,  1'b0}, // R2 seconds wrap
        '{1'b1, 4'd8, 32'd5000,     32'd90,  32'd0,  32'hFFFFFFFF, 32'h0, 8'd23, 1'b1}, // R8 budget used up
        '{1'b1, 4'd8, 32'd5000,     32'd90,  32'd0,  32'h000FFFFF, 32'h0, 8'd23, 1'b0}  // R8 last-chance accept
    };

    logic        clk = 1'b0;
    logic        rst_n, start, checked_mode, smp_vld;
    logic [31:0] smp_data;
    logic        smp_req, done, err;
    logic [31:0] result;

    int   n_tests = 0, n_fail = 0;
    int   cyc = 0, last_vld = 0, n_served = 0;
    bit   first_in_run = 1'b1;
    vec_t cur_v;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ctmr_sampler #(.GAP_CYCLES(GAP), .RETRY_MAX(20)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .checked_mode(checked_mode),
        .smp_req(smp_req), .smp_vld(smp_vld), .smp_data(smp_data),
        .result(result), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] to_word(input longint t);
        longint s, rem;
        s   = t / TPS;
        rem = t % TPS;
        return {7'(s), 13'(rem / 3072), 12'(rem % 3072)};
    endfunction

    function automatic logic [31:0] sample_val(input vec_t v, input int i);
        longint t;
        if (v.zmask[i]) return 32'd0;
        t = longint'(v.base) + longint'(v.step) * i;
        if (v.lmask[i]) t = t - longint'(v.lag);
        return to_word(t);
    endfunction

    // Timer model: answers each request two cycles late
    initial begin
        smp_vld  = 1'b0;
        smp_data = '0;
        forever begin
            @(negedge clk);
            if (smp_vld) begin
                smp_vld = 1'b0;
            end else if (smp_req && rst_n) begin
                if (!first_in_run)
                    check(cyc - last_vld > GAP, "R9 request spacing", cyc - last_vld, GAP + 1);
                first_in_run = 1'b0;
                repeat (2) @(negedge clk);
                smp_data = sample_val(cur_v, n_served);
                smp_vld  = 1'b1;
                n_served++;
                last_vld = cyc;
            end
        end
    end

    task automatic run(input vec_t v, input string tag);
        int       waited;
        logic [31:0] exp_res, held;
        cur_v        = v;
        n_served     = 0;
        first_in_run = 1'b1;
        @(negedge clk);
        checked_mode = v.mode;
        start        = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        waited = 0;
        while (!done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        exp_res = sample_val(v, int'(v.n) - 1);
        check(done === 1'b1, {tag, " done seen"}, done, 1);
        check(result === exp_res, {tag, " result"}, result, exp_res);
        check(err === v.err, {tag, " err"}, err, v.err);
        check(n_served == int'(v.n), {tag, " fetch count"}, n_served, v.n);
        held = result;
        @(negedge clk);
        check(done === 1'b0, "R10 done single pulse", done, 0);
        repeat (3) @(negedge clk);
        check(result === held && err === v.err, "R10 result held", result, held);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; checked_mode = 1'b0;
        cur_v = VECS[0];
        repeat (3) @(negedge clk);
        // R1: reset state
        check(smp_req === 1'b0, "R1 smp_req", smp_req, 0);
        check(done === 1'b0,    "R1 done", done, 0);
        check(err === 1'b0,     "R1 err", err, 0);
        check(result === 32'd0, "R1 result", result, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 12; k++)
            run(VECS[k], $sformatf("R%0d vec%0d", VECS[k].rq, k));

        // R1: reset in the middle of a checked run
        cur_v = VECS[10]; n_served = 0; first_in_run = 1'b1;
        @(negedge clk); checked_mode = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(smp_req === 1'b0 && done === 1'b0, "R1 mid-run reset req/done", smp_req, 0);
        check(result === 32'd0 && err === 1'b0, "R1 mid-run reset result", result, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        run(VECS[2], "R7 after reset");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule